// File: doc/BRIEF.md
# ATM VPI Lookup Address Generator

This block turns the virtual path identifier (VPI) of an incoming ATM cell header into a byte address inside a lookup-table memory. Each cell arrives with the number of the PHY port it came in on and the 12-bit VPI taken from the header. The block holds sixteen table configurations and picks one from the port number. When sixteen or fewer ports are in use, each port has its own table. When more are in use, pairs of ports share a table.

Each table configuration has four settings: a bit mask that chooses which VPI bits form the record index, a 16-bit base, a zero-check enable, and a flag that marks the port as a user-side (UNI) port. The chosen VPI bits are packed together into a dense index. The index is scaled by the record size, which is 8 or 16 bytes, and added to the table base to give a 19-bit address. When the zero-check is enabled, a cell with a nonzero VPI bit outside the mask is flagged as misrouted and counted in a saturating counter.

The configuration is written through a plain write port, one whole table per write. Results appear one clock cycle after the header strobe.

Top module: `vpi_addr_gen`

## Requirements
- R1: With `wide_mode`=0, port N (N in 0..15, using the low 4 port bits) uses table N.
- R2: With `wide_mode`=1, ports 2K and 2K+1 both use table K, with K = `hdr_port[4:1]`.
- R3: The VPI bits whose mask bit is 1 are packed into an index, keeping their order, with the lowest selected bit at index bit 0. VPI bits whose mask bit is 0 do not change the address.
- R4: With `rec16`=0, the address is ({base, 3'b000} + index*8), truncated to 19 bits. Address bits 2:0 are therefore always 0.
- R5: With `rec16`=1, base bit 0 is treated as 0 and the index is scaled by 16. Every valid address then has bits 3:0 equal to 0.
- R6: When a table's UNI flag is 1, only VPI bits 7:0 can form the index. VPI bits 11:8 are never used and never checked, whatever the mask holds.
- R7: When a table's check bit is 1 and any eligible VPI bit with mask bit 0 is nonzero, `misroute` is 1 and `lkup_valid` is 0. When the check bit is 0, a cell is never flagged as misrouted.
- R8: `lkup_valid`, `misroute` and `lkup_addr` update on the clock edge that samples `hdr_valid`=1, which is one cycle of latency. In a cycle that follows no strobe, both flags are 0.
- R9: `miss_cnt` goes up by one for each misrouted cell, on the same edge as `misroute`. It holds at 16'hFFFF once it reaches that value.
- R10: `cnt_clr` clears `miss_cnt` to 0 on the next edge, and takes priority over an increment. Reset clears the counter and every table configuration to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one table configuration |
| cfg_sel | input | 4 | Table number to write |
| cfg_mask | input | 12 | VPI bit mask to write |
| cfg_base | input | 16 | Table base to write (offset bits 18:3) |
| cfg_chk | input | 1 | Zero-check enable to write |
| cfg_uni | input | 1 | UNI flag to write |
| cnt_clr | input | 1 | Clears the misroute counter |
| wide_mode | input | 1 | 1 when more than 16 ports are in use |
| rec16 | input | 1 | 1 for 16-byte records, 0 for 8-byte records |
| hdr_valid | input | 1 | Header strobe |
| hdr_port | input | 5 | PHY port of the cell |
| hdr_vpi | input | 12 | VPI field of the header |
| lkup_valid | output | 1 | A good lookup address is ready |
| lkup_addr | output | 19 | Lookup byte address |
| misroute | output | 1 | The cell failed the zero-check |
| miss_cnt | output | 16 | Saturating count of misrouted cells |

## Verification
The hardest condition to reach from the ports is counter saturation, because it needs 65535 misrouted cells. The bench configures one table with a zero-check that fails and holds the header strobe high on that table for more than 65535 back-to-back cycles. It then confirms that the count stops at 16'hFFFF and that a clear still works. A second subtle case is a UNI port with a full mask and the check enabled: the bench sets the upper VPI bits high there and expects neither a misroute nor any effect on the address.

// File: rtl/vpi_lut_pkg.sv
package vpi_lut_pkg;
  localparam int VPI_W  = 12;
  localparam int GFC_W  = 4;
  localparam int BASE_W = 16;

  typedef struct packed {
    logic [VPI_W-1:0]  mask;
    logic [BASE_W-1:0] base;
    logic              chk;
    logic              uni;
  } tbl_cfg_t;
endpackage

// File: rtl/vpi_cfg_bank.sv
module vpi_cfg_bank
  import vpi_lut_pkg::*;
#(
  parameter int NUM_TBL = 16,
  localparam int SEL_W  = $clog2(NUM_TBL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  tbl_cfg_t         wdata,
  input  logic [SEL_W-1:0] rsel,
  output tbl_cfg_t         rcfg
);
  tbl_cfg_t entry [NUM_TBL];

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_entry
    logic     ent_en;
    tbl_cfg_t ent_nxt;

    always_comb begin
      ent_en  = we && (wsel == SEL_W'(t));
      ent_nxt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      entry[t] <= '0;
      else if (ent_en) entry[t] <= ent_nxt;
    end
  end

  assign rcfg = entry[rsel];
endmodule

// File: rtl/vpi_bit_compact.sv
module vpi_bit_compact #(
  parameter int W = 12,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0] din,
  input  logic [W-1:0] sel,
  output logic [W-1:0] dout
);
  logic [CW-1:0] pos;

  always_comb begin
    dout = '0;
    pos  = '0;
    for (int i = 0; i < W; i++) begin
      if (sel[i]) begin
        dout[pos] = din[i];
        pos       = pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vpi_sat_counter.sv
module vpi_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic         cnt_en;
  logic [W-1:0] cnt_nxt;

  always_comb begin
    cnt_en  = clr || (inc && (cnt != '1));
    cnt_nxt = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/vpi_addr_gen.sv
module vpi_addr_gen
  import vpi_lut_pkg::*;
#(
  parameter int NUM_TBL = 16,
  parameter int CNT_W   = 16,
  localparam int SEL_W  = $clog2(NUM_TBL),
  localparam int PORT_W = SEL_W + 1,
  localparam int ADDR_W = BASE_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [VPI_W-1:0]  cfg_mask,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              cfg_chk,
  input  logic              cfg_uni,
  input  logic              cnt_clr,
  input  logic              wide_mode,
  input  logic              rec16,
  input  logic              hdr_valid,
  input  logic [PORT_W-1:0] hdr_port,
  input  logic [VPI_W-1:0]  hdr_vpi,
  output logic              lkup_valid,
  output logic [ADDR_W-1:0] lkup_addr,
  output logic              misroute,
  output logic [CNT_W-1:0]  miss_cnt
);
  localparam logic [VPI_W-1:0] UNI_ELIG = {{GFC_W{1'b0}}, {(VPI_W-GFC_W){1'b1}}};

  tbl_cfg_t          wr_cfg, cur;
  logic [SEL_W-1:0]  tbl_sel;
  logic [VPI_W-1:0]  elig, use_mask, zero_bits, idx;
  logic [BASE_W-1:0] base_al;
  logic [ADDR_W-1:0] base_off, idx_off, addr_nxt;
  logic              bad, valid_nxt, mis_nxt, addr_en;

  always_comb begin
    wr_cfg.mask = cfg_mask;
    wr_cfg.base = cfg_base;
    wr_cfg.chk  = cfg_chk;
    wr_cfg.uni  = cfg_uni;
  end

  assign tbl_sel = wide_mode ? hdr_port[PORT_W-1:1] : hdr_port[SEL_W-1:0];

  vpi_cfg_bank #(.NUM_TBL(NUM_TBL)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wsel  (cfg_sel),
    .wdata (wr_cfg),
    .rsel  (tbl_sel),
    .rcfg  (cur)
  );

  always_comb begin
    elig      = cur.uni ? UNI_ELIG : '1;
    use_mask  = cur.mask & elig;
    zero_bits = elig & ~cur.mask;
    bad       = cur.chk && |(hdr_vpi & zero_bits);
  end

  vpi_bit_compact #(.W(VPI_W)) u_pack (
    .din  (hdr_vpi),
    .sel  (use_mask),
    .dout (idx)
  );

  always_comb begin
    base_al   = rec16 ? {cur.base[BASE_W-1:1], 1'b0} : cur.base;
    base_off  = {base_al, 3'b000};
    idx_off   = rec16 ? ADDR_W'({idx, 4'b0000}) : ADDR_W'({idx, 3'b000});
    addr_nxt  = base_off + idx_off;
    valid_nxt = hdr_valid && !bad;
    mis_nxt   = hdr_valid && bad;
    addr_en   = hdr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lkup_valid <= 1'b0;
      misroute   <= 1'b0;
    end else begin
      lkup_valid <= valid_nxt;
      misroute   <= mis_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lkup_addr <= '0;
    else if (addr_en) lkup_addr <= addr_nxt;
  end

  vpi_sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (mis_nxt),
    .cnt   (miss_cnt)
  );
endmodule

// File: rtl/vpi_addr_gen_chk.sv
module vpi_addr_gen_chk #(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_clr,
  input logic              rec16,
  input logic              hdr_valid,
  input logic              lkup_valid,
  input logic [ADDR_W-1:0] lkup_addr,
  input logic              misroute,
  input logic [CNT_W-1:0]  miss_cnt
);
  // R7
  excl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lkup_valid && misroute));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> (!lkup_valid && !misroute));

  // R4
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkup_valid |-> (lkup_addr[2:0] == 3'b000));

  // R5
  align16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && rec16) |=> (!lkup_valid || lkup_addr[3:0] == 4'h0));

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt == '1 && !cnt_clr) |=> (miss_cnt == '1));

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && miss_cnt != '1) |=>
      (miss_cnt == $past(miss_cnt) + {{(CNT_W-1){1'b0}}, misroute}));

  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (miss_cnt == '0));
endmodule

bind vpi_addr_gen vpi_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_clr    (cnt_clr),
  .rec16      (rec16),
  .hdr_valid  (hdr_valid),
  .lkup_valid (lkup_valid),
  .lkup_addr  (lkup_addr),
  .misroute   (misroute),
  .miss_cnt   (miss_cnt)
);

// File: tb/vpi_addr_gen_bench.sv
module vpi_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_chk, cfg_uni, cnt_clr, wide_mode, rec16, hdr_valid;
  logic [3:0]  cfg_sel;
  logic [11:0] cfg_mask, hdr_vpi;
  logic [15:0] cfg_base;
  logic [4:0]  hdr_port;
  logic        lkup_valid, misroute;
  logic [18:0] lkup_addr;
  logic [15:0] miss_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpi_addr_gen u_vpi_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_mask(cfg_mask), .cfg_base(cfg_base), .cfg_chk(cfg_chk),
    .cfg_uni(cfg_uni), .cnt_clr(cnt_clr), .wide_mode(wide_mode),
    .rec16(rec16), .hdr_valid(hdr_valid), .hdr_port(hdr_port),
    .hdr_vpi(hdr_vpi), .lkup_valid(lkup_valid), .lkup_addr(lkup_addr),
    .misroute(misroute), .miss_cnt(miss_cnt)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(int sel, int mask, int base, bit chk, bit uni);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 4'(sel); cfg_mask = 12'(mask);
    cfg_base = 16'(base); cfg_chk = chk; cfg_uni = uni;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // One strobe; returns at the negedge where the registered results are visible.
  task automatic send(int port, int vpi);
    @(negedge clk);
    hdr_valid = 1; hdr_port = 5'(port); hdr_vpi = 12'(vpi);
    @(negedge clk);
    hdr_valid = 0;
  endtask

  task automatic expect_hit(string req, int addr);
    check({req, " valid"}, int'(lkup_valid), 1);
    check({req, " misroute"}, int'(misroute), 0);
    check({req, " addr"}, int'(lkup_addr), addr);
  endtask

  task automatic t_reset();
    check("R10 reset valid", int'(lkup_valid), 0);
    check("R10 reset misroute", int'(misroute), 0);
    check("R10 reset count", int'(miss_cnt), 0);
    send(3, 'hABC);            // cleared config: mask 0, base 0
    expect_hit("R10 reset config", 0);
  endtask

  task automatic t_compact();
    cfg_write(2, 'h0F0, 'h0010, 0, 0);
    send(2, 'hA5C);            // bits 7:4 = 5 -> 0x80 + 0x28
    expect_hit("R3 R4 nibble", 'hA8);
    send(2, 'hF53);            // other bits differ, same selected bits
    expect_hit("R3 ignored bits", 'hA8);
    cfg_write(2, 'h821, 'h0010, 0, 0);
    send(2, 'h801);            // bits 0,11 -> index 0b101
    expect_hit("R3 scattered", 'hA8);
    send(2, 'h020);            // bit 5 -> index 0b010
    expect_hit("R3 scattered mid", 'h90);
  endtask

  task automatic t_rec16();
    cfg_write(2, 'h00F, 'h0011, 0, 0);
    rec16 = 1;
    send(2, 3);                // base lsb dropped: 0x80 + 3*16
    expect_hit("R5 rec16", 'hB0);
    rec16 = 0;
    send(2, 3);                // 0x88 + 3*8
    expect_hit("R4 rec8", 'hA0);
  endtask

  task automatic t_ports();
    cfg_write(7, 0, 'h0100, 0, 0);
    cfg_write(6, 0, 'h0200, 0, 0);
    wide_mode = 0;
    send(7, 'h123);
    expect_hit("R1 port7", 'h800);
    send(6, 0);
    expect_hit("R1 port6", 'h1000);
    send(23, 0);               // low 4 bits = 7
    expect_hit("R1 low bits", 'h800);
    wide_mode = 1;
    send(13, 0);
    expect_hit("R2 port13", 'h1000);
    send(14, 0);
    expect_hit("R2 port14", 'h800);
    send(15, 0);
    expect_hit("R2 port15", 'h800);
    wide_mode = 0;
  endtask

  task automatic t_uni();
    cfg_write(9, 'hFFF, 0, 1, 1);
    send(9, 'hF03);
    expect_hit("R6 uni gfc", 'h18);
  endtask

  task automatic t_check();
    cfg_write(9, 'h0FF, 0, 1, 0);
    send(9, 'h103);
    check("R7 misroute", int'(misroute), 1);
    check("R7 no valid", int'(lkup_valid), 0);
    check("R9 count one", int'(miss_cnt), 1);
    @(negedge clk);
    check("R8 idle valid", int'(lkup_valid), 0);
    check("R8 idle misroute", int'(misroute), 0);
    cfg_write(9, 'h0FF, 0, 0, 0);
    send(9, 'h103);
    expect_hit("R7 check off", 'h18);
    check("R9 count kept", int'(miss_cnt), 1);
  endtask

  task automatic t_saturate();
    cfg_write(9, 'h0FF, 0, 1, 0);
    @(negedge clk);
    hdr_valid = 1; hdr_port = 9; hdr_vpi = 'h800;
    repeat (65540) @(negedge clk);
    hdr_valid = 0;
    check("R9 saturate", int'(miss_cnt), 'hFFFF);
    @(negedge clk);
    check("R9 hold", int'(miss_cnt), 'hFFFF);
    cnt_clr = 1;
    hdr_valid = 1;             // clear wins over a misroute
    @(negedge clk);
    cnt_clr = 0; hdr_valid = 0;
    check("R10 clear", int'(miss_cnt), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_mask = 0; cfg_base = 0;
    cfg_chk = 0; cfg_uni = 0; cnt_clr = 0; wide_mode = 0; rec16 = 0;
    hdr_valid = 0; hdr_port = 0; hdr_vpi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_compact();
    t_rec16();
    t_ports();
    t_uni();
    t_check();
    t_saturate();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule